// File: doc/BRIEF.md
# Edge-to-Pulse Encoder with Refresh

This block is the sending half of a link that carries logic levels as short pulses rather than as levels. Every channel takes a logic input, brings it into the local clock domain and sends a one-cycle "set" pulse for each rising edge and a one-cycle "clear" pulse for each falling edge. A receiver holding a bistable latch rebuilds the level from these pulses.

A latch driven only by edges never recovers if a pulse is lost. The encoder therefore also sends keep-alive pulses while its input sits still. After a programmable quiet time following an edge, it sends a set pulse if the input is high or a clear pulse if it is low. It repeats that pulse at a programmable period for as long as the input stays unchanged.

Out of reset, each channel first sends one keep-alive pulse of its present level, so the far latch starts out correct. The channels are copies that share nothing except the clock and the reset.

Top module: `edge_pulse_tx`

## Requirements
- R1: A rising edge of a channel input gives exactly one set pulse on that channel, three clock edges after the first clock edge that samples the new value.
- R2: A falling edge of a channel input gives exactly one clear pulse, with the same three-edge latency.
- R3: Every set or clear pulse is high for exactly one clock cycle, and no pulse appears in a cycle in which no rule below calls for one.
- R4: A channel never raises set and clear in the same cycle.
- R5: A keep-alive pulse is sent IDLE_CYCLES cycles after an edge pulse if no new edge has arrived in between. It is a set pulse when the synchronized level is 1 and a clear pulse when the level is 0.
- R6: While the input stays unchanged, further keep-alive pulses of the same polarity follow every REFRESH_CYCLES cycles after the previous keep-alive pulse.
- R7: When an edge pulse and a keep-alive pulse fall due in the same cycle, only the edge pulse is sent, and the next keep-alive pulse is then IDLE_CYCLES cycles later.
- R8: The channels are independent. Edges and keep-alive timing on one channel have no effect on the pulses of another.
- R9: While reset is low both outputs are 0. After reset is released, the first pulse on each channel is a keep-alive pulse of the level sampled at the first clock edge after release, and it appears at the third clock edge after release.
- R10: An input high or low for a single sampled cycle still produces its edge pulse and the following opposite edge pulse in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all channels |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_in | input | NUM_CH | Asynchronous logic level, one bit per channel |
| set_pulse | output | NUM_CH | One-cycle pulse meaning "level is now high" |
| clr_pulse | output | NUM_CH | One-cycle pulse meaning "level is now low" |

## Verification
An edge pulse and a keep-alive pulse can fall due in the same cycle. The bench provokes this by toggling an input exactly IDLE_CYCLES cycles after the previous toggle, and again IDLE_CYCLES plus REFRESH_CYCLES cycles after a toggle, so that a fresh edge meets a due keep-alive pulse both after an edge and after a keep-alive. The behavioural model gives priority to the edge and restarts the quiet time. Each such cycle is compared on both output lines, and so is every later keep-alive position, so a merged pulse, a doubled pulse or a timer that was not restarted all show up as mismatches tagged R7.

// File: rtl/edge_pulse_pkg.sv
// Package: shared types for the edge-to-pulse encoder.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package edge_pulse_pkg;

    // Kind of the most recent pulse sent; selects the next keep-alive interval.
    typedef enum logic {
        LAST_EDGE    = 1'b0,
        LAST_REFRESH = 1'b1
    } last_kind_t;

    // Larger of two positive counts, used to size interval counters.
    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edge_pulse_sync.sv
// Module: edge_pulse_sync
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a level that may be sampled on its own. No bus coherence
// is implied. Stages reset to 0.
module edge_pulse_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous bits through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/edge_pulse_chan.sv
// Module: edge_pulse_chan
// One encoder channel. It turns edges of a synchronized level into registered
// one-cycle set/clear pulses and adds keep-alive pulses while the level is idle.
// Assumes lvl_i is already synchronous. Edge detection starts only after
// FILL_CYCLES clock edges past reset, which is the time the synchronizer needs
// to hold valid data. The first pulse after reset is a keep-alive pulse.
module edge_pulse_chan
    import edge_pulse_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES    = 100,
    parameter int unsigned REFRESH_CYCLES = 85,
    parameter int unsigned FILL_CYCLES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic set_o,
    output logic clr_o
);

    localparam int unsigned MAXC = max_of(IDLE_CYCLES, REFRESH_CYCLES);
    localparam int unsigned CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam int unsigned FW   = $clog2(FILL_CYCLES + 1);
    localparam logic [CW-1:0] IDLE_LAST    = CW'(IDLE_CYCLES - 1);
    localparam logic [CW-1:0] REFRESH_LAST = CW'(REFRESH_CYCLES - 1);
    localparam logic [FW-1:0] FILL_DONE    = FW'(FILL_CYCLES);

    logic [FW-1:0] fill_q;
    logic          started_q;
    logic          prev_q;
    logic [CW-1:0] cnt_q;
    last_kind_t    kind_q;
    logic          set_q, clr_q;

    logic          primed, startup_due, edge_seen, refresh_due, fire;
    logic [CW-1:0] cnt_last;

    // Decide which pulse, if any, is sent at the next clock edge.
    always_comb begin
        primed      = (fill_q == FILL_DONE);
        startup_due = primed && !started_q;
        edge_seen   = started_q && (lvl_i != prev_q);
        cnt_last    = (kind_q == LAST_EDGE) ? IDLE_LAST : REFRESH_LAST;
        refresh_due = started_q && !edge_seen && (cnt_q == cnt_last);
        fire        = startup_due || edge_seen || refresh_due;
    end

    // Count the cycles the synchronizer needs to fill after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       fill_q <= '0;
        else if (!primed) fill_q <= fill_q + 1'b1;
    end

    // Track the last level sent, the interval timer and the kind of the last pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            prev_q    <= 1'b0;
            cnt_q     <= '0;
            kind_q    <= LAST_REFRESH;
        end else begin
            if (startup_due) started_q <= 1'b1;
            if (fire) begin
                prev_q <= lvl_i;
                cnt_q  <= '0;
                kind_q <= edge_seen ? LAST_EDGE : LAST_REFRESH;
            end else if (started_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Register the pulse outputs; polarity always follows the present level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            set_q <= fire && lvl_i;
            clr_q <= fire && !lvl_i;
        end
    end

    assign set_o = set_q;
    assign clr_o = clr_q;

    // R4: the two pulse lines are mutually exclusive.
    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_o && clr_o));

    // R3: a pulse never lasts two cycles.
    assert_set_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |=> !set_o);
    assert_clr_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);

    // R1: a detected rising level is followed by a set pulse.
    assert_rise_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && lvl_i && !prev_q) |=> (set_o && !clr_o));

    // R2: a detected falling level is followed by a clear pulse.
    assert_fall_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !lvl_i && prev_q) |=> (clr_o && !set_o));

    // R9: the cycle that marks the channel started carries the startup pulse.
    assert_startup_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(started_q) |-> (set_o || clr_o));

endmodule

// File: rtl/edge_pulse_tx.sv
// Module: edge_pulse_tx (top)
// Multi-channel transmit side of a pulse-coded isolation link. It synchronizes
// every input bit and drives one independent encoder channel per bit.
// Assumes inputs are asynchronous levels. Pulses are registered, one cycle wide.
module edge_pulse_tx #(
    parameter int unsigned NUM_CH         = 2,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned IDLE_CYCLES    = 100,
    parameter int unsigned REFRESH_CYCLES = 85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sig_in,
    output logic [NUM_CH-1:0] set_pulse,
    output logic [NUM_CH-1:0] clr_pulse
);

    logic [NUM_CH-1:0] lvl;

    edge_pulse_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_in),
        .sync_o  (lvl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        edge_pulse_chan #(
            .IDLE_CYCLES    (IDLE_CYCLES),
            .REFRESH_CYCLES (REFRESH_CYCLES),
            .FILL_CYCLES    (SYNC_STAGES)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (lvl[c]),
            .set_o (set_pulse[c]),
            .clr_o (clr_pulse[c])
        );
    end

endmodule

// File: tb/test_edge_pulse_tx.sv
// Bench for edge_pulse_tx: a behavioural model built from the requirements
// runs beside the design and is compared on every clock cycle.
module test_edge_pulse_tx;

    localparam int NUM_CH  = 2;
    localparam int IDLE    = 100;
    localparam int REFRESH = 85;
    localparam int LAT     = 3;   // edges from first sample to pulse (R1, R2, R9)

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] sig_in = '0;
    logic [NUM_CH-1:0] set_pulse, clr_pulse;

    int checks = 0;
    int fails  = 0;
    int collisions = 0;
    bit done = 1'b0;

    edge_pulse_tx #(
        .NUM_CH(NUM_CH), .SYNC_STAGES(2),
        .IDLE_CYCLES(IDLE), .REFRESH_CYCLES(REFRESH)
    ) i_edge_pulse_tx (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
        .set_pulse(set_pulse), .clr_pulse(clr_pulse)
    );

    always #5 clk = ~clk;   // 100 MHz

    // ---------------- behavioural model ----------------
    logic [NUM_CH-1:0] hist[$];          // input samples since reset
    int     edges_since_rst;
    int     since_pulse [NUM_CH];
    bit     last_was_edge [NUM_CH];
    bit     sent_level [NUM_CH];
    int     since_edge [NUM_CH];
    bit     exp_set [NUM_CH];
    bit     exp_clr [NUM_CH];
    string  why [NUM_CH];

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            edges_since_rst = 0;
            for (int c = 0; c < NUM_CH; c++) begin
                exp_set[c] = 0; exp_clr[c] = 0; why[c] = "R9";
                since_pulse[c] = 0; last_was_edge[c] = 0; sent_level[c] = 0;
                since_edge[c] = 1000;
            end
        end else begin
            edges_since_rst++;
            hist.push_back(sig_in);
            if (hist.size() > LAT) void'(hist.pop_front());
            for (int c = 0; c < NUM_CH; c++) begin
                exp_set[c] = 0; exp_clr[c] = 0; why[c] = "R3";
                if (edges_since_rst == LAT) begin
                    // R9: startup keep-alive of the first sampled level
                    sent_level[c] = hist[0][c];
                    exp_set[c] = sent_level[c]; exp_clr[c] = !sent_level[c];
                    since_pulse[c] = 0; last_was_edge[c] = 0; why[c] = "R9";
                    since_edge[c] = 1000;
                end else if (edges_since_rst > LAT) begin
                    bit lv;
                    int limit;
                    lv = hist[0][c];
                    limit = last_was_edge[c] ? IDLE : REFRESH;
                    since_pulse[c]++;
                    since_edge[c]++;
                    if (lv != sent_level[c]) begin
                        if (since_pulse[c] == limit) begin
                            why[c] = "R7"; collisions++;
                        end else if (since_edge[c] == 1) why[c] = "R10";
                        else why[c] = lv ? "R1" : "R2";
                        sent_level[c] = lv;
                        exp_set[c] = lv; exp_clr[c] = !lv;
                        since_pulse[c] = 0; last_was_edge[c] = 1; since_edge[c] = 0;
                    end else if (since_pulse[c] == limit) begin
                        why[c] = last_was_edge[c] ? "R5" : "R6";
                        exp_set[c] = lv; exp_clr[c] = !lv;
                        since_pulse[c] = 0; last_was_edge[c] = 0;
                    end
                end
            end
        end
    end

    // Compare away from the active edge; R8: each channel judged on its own.
    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < NUM_CH; c++) begin
                checks++;
                if (set_pulse[c] !== exp_set[c] || clr_pulse[c] !== exp_clr[c]) begin
                    fails++;
                    $display("FAIL %s (R8 ch%0d) t=%0t: set/clr actual %b%b expected %b%b",
                             why[c], c, $time, set_pulse[c], clr_pulse[c],
                             exp_set[c], exp_clr[c]);
                end
                checks++;
                if (set_pulse[c] === 1'b1 && clr_pulse[c] === 1'b1) begin
                    fails++;
                    $display("FAIL R4 ch%0d t=%0t: set/clr actual 11 expected not both", c, $time);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        // R9: reset with channel 1 high, channel 0 low.
        sig_in = 2'b10;
        tick(5);
        rst_n = 1'b1;
        tick(300);                         // startup + R6 periodic keep-alives

        // R1/R2 on channel 0 while channel 1 stays idle (R8).
        sig_in[0] = 1'b1; tick(40);
        sig_in[0] = 1'b0; tick(1);         // R10 single-cycle levels
        sig_in[0] = 1'b1; tick(1);
        sig_in[0] = 1'b0; tick(250);       // R5 then R6

        // R7: edge lands exactly when the post-edge keep-alive is due.
        sig_in[0] = 1'b1; tick(IDLE);
        sig_in[0] = 1'b0; tick(IDLE + REFRESH);
        // R7: edge lands exactly when a periodic keep-alive is due.
        sig_in[0] = 1'b1; tick(60);

        // Channel 1 activity with its own timing (R8).
        sig_in[1] = 1'b0; tick(37);
        sig_in[1] = 1'b1; tick(IDLE);
        sig_in[1] = 1'b0; tick(3);
        sig_in[0] = 1'b0; tick(400);

        // Both channels toggling in the same cycle.
        sig_in = 2'b11; tick(150);
        sig_in = 2'b00; tick(1);
        sig_in = 2'b11; tick(300);

        // Reset in mid-run, release with mixed levels (R9).
        rst_n = 1'b0; sig_in = 2'b01; tick(3);
        rst_n = 1'b1; tick(2);
        sig_in = 2'b10; tick(400);

        if (collisions == 0) begin
            checks++; fails++;
            $display("FAIL R7: collisions actual 0 expected >0");
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule